// File: doc/BRIEF.md
# Banked Memory Mapper Register Unit

This block sits between a CPU, a video controller and a cartridge ROM. It turns CPU writes in the upper half of the address space into bank-selection state. From that state it maps both address streams onto physical ROM addresses. The CPU sees a 32 KB program window made of four 8 KB slots. Two of those slots can be switched, and the other two are pinned near the end of program ROM. The video side sees an 8 KB pattern window of eight 1 KB slots. Those slots are fed by two 2 KB banks and four 1 KB banks.

Bank programming is indirect. A select write names a target bank and sets two layout bits. A following data write loads the named target. One layout bit moves the switchable program bank between slot 0 and slot 2. The other exchanges the upper and lower halves of the pattern window. The block also drives a nametable mirroring mode. It decodes four writes that belong to an interrupt counter elsewhere, and hands each of them out as a one-cycle strobe together with the write data. Address translation is purely combinational. Register writes take effect on the clock edge at which `wr_en` is sampled high.

Top module: `bank_mapper_top`

## Requirements
- R1: A write is decoded only when `wr_en` is 1 and `wr_addr[15]` is 1. Only bits 15, 14, 13 and 0 take part, so every alias of a register behaves the same way. The register map is:
  - {14,13,0}=000: select
  - 001: bank data
  - 010: mirroring
  - 011: accepted with no effect on any output
  - 100 to 111: interrupt strobes
- R2: `irq_wr` is one-hot or zero, and it follows the write combinationally. Bit 0 marks the 0xC000 form, bit 1 the 0xC001 form, bit 2 the 0xE000 form and bit 3 the 0xE001 form. `irq_data` equals `wr_data`.
- R3: Bits 2:0 of the last select byte name the target of a bank data write:
  - 0 and 1: the two 2 KB pattern banks
  - 2 to 5: the four 1 KB pattern banks
  - 6 and 7: the two program banks

  The new bank is visible on the translated outputs from the clock edge that captures the write.
- R4: Program slot k is `cpu_addr[14:13]`. The slot's source depends on select bit 6:

  | Slot | Select bit 6 = 0 | Select bit 6 = 1 |
  |------|------------------|------------------|
  | 0 | bank 6 | second-to-last bank |
  | 1 | bank 7 | bank 7 |
  | 2 | second-to-last bank | bank 6 |
  | 3 | last bank | last bank |

- R5: Pattern slot s is `ppu_addr[12:10]`. With select bit 7 clear, slots 0 and 1 hold pages n and n+1 of 2 KB bank 0, and slots 2 and 3 hold the two pages of bank 1. Slots 4 to 7 hold 1 KB banks 2 to 5. With select bit 7 set, the two halves are exchanged. Data written to targets 0 and 1 has bit 0 forced to 0.
- R6: Every bank number is reduced modulo the bank count, which is a power of two.
- R7: Without pattern ROM, slot s maps to RAM page s whatever the swap bit, and pattern bank writes are ignored.
- R8: Mirroring data bit 0 chooses the mode: 1 gives `mirror_mode`=01 (horizontal) and 0 gives 00 (vertical). In four-screen configuration, `mirror_mode` is always 10.
- R9: Reset sets the select byte to 0, the program banks to 0 and 1, and the pattern banks 0 to 5 to 0, 2, 4, 5, 6 and 7. Mirroring resets to vertical.
- R10: The physical program address is {bank, `cpu_addr[12:0]`}. The physical pattern address is {page, `ppu_addr[9:0]`}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write qualifier |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 15 | CPU read address inside the 32 KB program window |
| prg_addr | output | PRG_BW+13 | Physical program ROM address |
| ppu_addr | input | 13 | Video pattern address |
| chr_addr | output | CHR_BW+10 | Physical pattern ROM or RAM address |
| mirror_mode | output | 2 | 00 vertical, 01 horizontal, 10 four-screen |
| irq_wr | output | 4 | One-hot strobes for the interrupt counter writes |
| irq_data | output | 8 | Data that goes with `irq_wr` |

## Verification
A wrong bank register or a wrong layout bit shows up at once on `prg_addr` or `chr_addr`. It appears on the first cycle after the faulty write, but only while the probe address falls in an affected slot. For that reason every write in the vector table is followed by a probe of a slot that the write could have disturbed. A bad decode of the aliased address bits is seen in the same cycle on `irq_wr`. It is seen one cycle later on `mirror_mode` or on the translated addresses. An error in 2 KB pairing only shows on the odd slot of a pair, so both halves of each pair are probed.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;

  typedef struct packed {
    logic       sel_we;
    logic       data_we;
    logic       mirror_we;
    logic [3:0] irq_we;
  } wr_strobe_t;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'b00,
    MIR_HORIZ = 2'b01,
    MIR_FOUR  = 2'b10
  } mirror_t;

  typedef enum logic [1:0] {
    SRC_BANK6  = 2'd0,
    SRC_BANK7  = 2'd1,
    SRC_PENULT = 2'd2,
    SRC_LAST   = 2'd3
  } prg_src_t;

  // Power-on value of bank register idx (0..7).
  function automatic logic [7:0] bank_reset_value(input int idx);
    if (idx < 2)      return 8'(2 * idx);
    else if (idx < 6) return 8'(idx + 2);
    else              return 8'(idx - 6);
  endfunction

  // Where a program slot takes its bank from.
  function automatic prg_src_t prg_source(input logic [1:0] slot, input logic swap);
    case (slot)
      2'd0:    return swap ? SRC_PENULT : SRC_BANK6;
      2'd1:    return SRC_BANK7;
      2'd2:    return swap ? SRC_BANK6 : SRC_PENULT;
      default: return SRC_LAST;
    endcase
  endfunction

  // Pattern slot after the half exchange.
  function automatic logic [2:0] chr_eff_slot(input logic [2:0] slot, input logic swap);
    return slot ^ {swap, 2'b00};
  endfunction

endpackage

// File: rtl/mapper_wr_decode.sv
`timescale 1ns/1ps
module mapper_wr_decode
  import mapper_pkg::*;
(
  input  logic       wr_en,
  input  logic [3:0] key,      // {a15, a14, a13, a0}
  output wr_strobe_t stb
);
  logic       hit;
  logic [2:0] code;

  assign hit  = wr_en & key[3];
  assign code = key[2:0];

  always_comb begin
    stb = '0;
    if (hit) begin
      stb.sel_we    = (code == 3'd0);
      stb.data_we   = (code == 3'd1);
      stb.mirror_we = (code == 3'd2);
      for (int k = 0; k < 4; k++)
        stb.irq_we[k] = (code == 3'(4 + k));
    end
  end
endmodule

// File: rtl/mapper_bank_file.sv
`timescale 1ns/1ps
module mapper_bank_file
  import mapper_pkg::*;
#(
  parameter int PRG_BW          = 4,
  parameter int CHR_BW          = 7,
  parameter bit CHR_ROM_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strobe_t        stb,
  input  logic [7:0]        wr_data,
  output logic              prg_swap,
  output logic              chr_swap,
  output logic [PRG_BW-1:0] prg_bank [2],
  output logic [CHR_BW-1:0] chr_bank [6],
  output logic              mirror_bit
);
  localparam int NUM_CHR = 6;
  localparam int NUM_PRG = 2;

  logic [2:0] target_q;
  logic       chr_we;
  logic       unused_data;

  assign unused_data = ^wr_data;
  assign chr_we      = stb.data_we & CHR_ROM_PRESENT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q   <= '0;
      prg_swap   <= 1'b0;
      chr_swap   <= 1'b0;
      mirror_bit <= 1'b0;
    end else begin
      if (stb.sel_we) begin
        target_q <= wr_data[2:0];
        prg_swap <= wr_data[6];
        chr_swap <= wr_data[7];
      end
      if (stb.mirror_we)
        mirror_bit <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PRG; i++)
        prg_bank[i] <= PRG_BW'(bank_reset_value(i + 6));
    end else begin
      for (int i = 0; i < NUM_PRG; i++)
        if (stb.data_we && target_q == 3'(i + 6))
          prg_bank[i] <= wr_data[PRG_BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CHR; i++)
        chr_bank[i] <= CHR_BW'(bank_reset_value(i));
    end else begin
      for (int i = 0; i < NUM_CHR; i++)
        if (chr_we && target_q == 3'(i))
          chr_bank[i] <= (i < 2) ? {wr_data[CHR_BW-1:1], 1'b0}
                                 : wr_data[CHR_BW-1:0];
    end
  end
endmodule

// File: rtl/mapper_prg_xlate.sv
`timescale 1ns/1ps
module mapper_prg_xlate
  import mapper_pkg::*;
#(
  parameter int PRG_BW = 4
) (
  input  logic [14:0]        cpu_addr,
  input  logic               prg_swap,
  input  logic [PRG_BW-1:0]  prg_bank [2],
  output logic [PRG_BW+12:0] prg_addr
);
  localparam logic [PRG_BW-1:0] LAST_BANK   = {PRG_BW{1'b1}};
  localparam logic [PRG_BW-1:0] PENULT_BANK = LAST_BANK - 1'b1;

  prg_src_t          src;
  logic [PRG_BW-1:0] bank;

  assign src = prg_source(cpu_addr[14:13], prg_swap);

  always_comb begin
    case (src)
      SRC_BANK6:  bank = prg_bank[0];
      SRC_BANK7:  bank = prg_bank[1];
      SRC_PENULT: bank = PENULT_BANK;
      default:    bank = LAST_BANK;
    endcase
  end

  assign prg_addr = {bank, cpu_addr[12:0]};
endmodule

// File: rtl/mapper_chr_xlate.sv
`timescale 1ns/1ps
module mapper_chr_xlate
  import mapper_pkg::*;
#(
  parameter int CHR_BW          = 7,
  parameter bit CHR_ROM_PRESENT = 1'b1
) (
  input  logic [12:0]        ppu_addr,
  input  logic               chr_swap,
  input  logic [CHR_BW-1:0]  chr_bank [6],
  output logic [CHR_BW+9:0]  chr_addr
);
  localparam int CHR_AW = CHR_BW + 10;

  generate
    if (CHR_ROM_PRESENT) begin : g_rom
      logic [2:0]        eff;
      logic [CHR_BW-1:0] pair;
      logic [CHR_BW-1:0] page;

      assign eff  = chr_eff_slot(ppu_addr[12:10], chr_swap);
      assign pair = eff[1] ? chr_bank[1] : chr_bank[0];

      always_comb begin
        if (!eff[2])
          page = {pair[CHR_BW-1:1], eff[0]};
        else
          page = chr_bank[3'd2 + {1'b0, eff[1:0]}];
      end

      assign chr_addr = {page, ppu_addr[9:0]};
    end else begin : g_ram
      logic unused_bank;
      assign unused_bank = chr_swap ^ (^chr_bank[0]) ^ (^chr_bank[1]) ^ (^chr_bank[2])
                         ^ (^chr_bank[3]) ^ (^chr_bank[4]) ^ (^chr_bank[5]);
      assign chr_addr = CHR_AW'(ppu_addr);
    end
  endgenerate
endmodule

// File: rtl/bank_mapper_top.sv
`timescale 1ns/1ps
module bank_mapper_top
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS       = 16,
  parameter int CHR_BANKS       = 128,
  parameter bit CHR_ROM_PRESENT = 1'b1,
  parameter bit FOUR_SCREEN     = 1'b0,
  localparam int PRG_BW         = $clog2(PRG_BANKS),
  localparam int CHR_BW         = $clog2(CHR_BANKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [15:0]        wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [14:0]        cpu_addr,
  output logic [PRG_BW+12:0] prg_addr,
  input  logic [12:0]        ppu_addr,
  output logic [CHR_BW+9:0]  chr_addr,
  output logic [1:0]         mirror_mode,
  output logic [3:0]         irq_wr,
  output logic [7:0]         irq_data
);
  wr_strobe_t        stb;
  logic              prg_swap;
  logic              chr_swap;
  logic              mirror_bit;
  logic [PRG_BW-1:0] prg_bank [2];
  logic [CHR_BW-1:0] chr_bank [6];
  logic              unused_addr;

  assign unused_addr = ^wr_addr[12:1];

  mapper_wr_decode u_dec (
    .wr_en (wr_en),
    .key   ({wr_addr[15:13], wr_addr[0]}),
    .stb   (stb)
  );

  mapper_bank_file #(
    .PRG_BW          (PRG_BW),
    .CHR_BW          (CHR_BW),
    .CHR_ROM_PRESENT (CHR_ROM_PRESENT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .wr_data    (wr_data),
    .prg_swap   (prg_swap),
    .chr_swap   (chr_swap),
    .prg_bank   (prg_bank),
    .chr_bank   (chr_bank),
    .mirror_bit (mirror_bit)
  );

  mapper_prg_xlate #(.PRG_BW(PRG_BW)) u_prg (
    .cpu_addr (cpu_addr),
    .prg_swap (prg_swap),
    .prg_bank (prg_bank),
    .prg_addr (prg_addr)
  );

  mapper_chr_xlate #(
    .CHR_BW          (CHR_BW),
    .CHR_ROM_PRESENT (CHR_ROM_PRESENT)
  ) u_chr (
    .ppu_addr (ppu_addr),
    .chr_swap (chr_swap),
    .chr_bank (chr_bank),
    .chr_addr (chr_addr)
  );

  mirror_t mir;
  assign mir         = FOUR_SCREEN ? MIR_FOUR : (mirror_bit ? MIR_HORIZ : MIR_VERT);
  assign mirror_mode = mir;
  assign irq_wr      = stb.irq_we;
  assign irq_data    = wr_data;
endmodule

// File: rtl/mapper_checker.sv
`timescale 1ns/1ps
module mapper_checker #(
  parameter int PRG_BANKS       = 16,
  parameter int CHR_BANKS       = 128,
  parameter bit CHR_ROM_PRESENT = 1'b1,
  parameter bit FOUR_SCREEN     = 1'b0,
  localparam int PRG_BW         = $clog2(PRG_BANKS),
  localparam int CHR_BW         = $clog2(CHR_BANKS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [15:0]        wr_addr,
  input logic [7:0]         wr_data,
  input logic [14:0]        cpu_addr,
  input logic [PRG_BW+12:0] prg_addr,
  input logic [12:0]        ppu_addr,
  input logic [CHR_BW+9:0]  chr_addr,
  input logic [1:0]         mirror_mode,
  input logic [3:0]         irq_wr,
  input logic               prg_swap
);
  localparam logic [PRG_BW-1:0] LAST = {PRG_BW{1'b1}};

  assert_irq_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_wr));

  assert_decode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !wr_addr[15]) |-> (irq_wr == 4'b0000));

  assert_prg_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'd3) |-> (prg_addr[PRG_BW+12:13] == LAST));

  assert_prg_penult_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((prg_swap && cpu_addr[14:13] == 2'd0) || (!prg_swap && cpu_addr[14:13] == 2'd2))
      |-> (prg_addr[PRG_BW+12:13] == LAST - 1'b1));

  assert_offsets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_addr[12:0] == cpu_addr[12:0]) && (chr_addr[9:0] == ppu_addr[9:0]));

  generate
    if (FOUR_SCREEN) begin : g_four
      assert_four_screen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_mode == 2'b10);
    end else begin : g_mir
      assert_mirror_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:13] == 3'b101 && !wr_addr[0])
          |=> (mirror_mode == {1'b0, $past(wr_data[0])}));
    end
    if (!CHR_ROM_PRESENT) begin : g_ram
      assert_ram_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[12:0] == ppu_addr);
    end
  endgenerate
endmodule

bind bank_mapper_top mapper_checker #(
  .PRG_BANKS       (PRG_BANKS),
  .CHR_BANKS       (CHR_BANKS),
  .CHR_ROM_PRESENT (CHR_ROM_PRESENT),
  .FOUR_SCREEN     (FOUR_SCREEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .cpu_addr    (cpu_addr),
  .prg_addr    (prg_addr),
  .ppu_addr    (ppu_addr),
  .chr_addr    (chr_addr),
  .mirror_mode (mirror_mode),
  .irq_wr      (irq_wr),
  .prg_swap    (prg_swap)
);

// File: tb/tb_bank_mapper_top.sv
`timescale 1ns/1ps
module tb_bank_mapper_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] cpu_addr = '0;
  logic [12:0] ppu_addr = '0;
  logic [16:0] prg_addr, prg_addr_r;
  logic [16:0] chr_addr;
  logic [12:0] chr_addr_r;
  logic [1:0]  mirror_mode, mirror_mode_r;
  logic [3:0]  irq_wr, irq_wr_r;
  logic [7:0]  irq_data, irq_data_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_mapper_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .prg_addr(prg_addr), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
    .mirror_mode(mirror_mode), .irq_wr(irq_wr), .irq_data(irq_data)
  );

  bank_mapper_top #(.PRG_BANKS(16), .CHR_BANKS(8), .CHR_ROM_PRESENT(1'b0),
                    .FOUR_SCREEN(1'b1)) dut_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .prg_addr(prg_addr_r), .ppu_addr(ppu_addr), .chr_addr(chr_addr_r),
    .mirror_mode(mirror_mode_r), .irq_wr(irq_wr_r), .irq_data(irq_data_r)
  );

  // {wr_addr, wr_data, cpu_addr, expected prg_addr, ppu_addr, expected chr_addr}
  localparam int NV = 13;
  localparam logic [85:0] VEC [NV] = '{
    {16'h8000, 8'h06, 15'h0123, {4'd0,  13'h0123}, 13'h0000, {7'd0,   10'h000}},
    {16'h8001, 8'h23, 15'h0456, {4'd3,  13'h0456}, 13'h1C05, {7'd7,   10'h005}},
    {16'h8000, 8'h07, 15'h2010, {4'd1,  13'h0010}, 13'h1001, {7'd4,   10'h001}},
    {16'h8001, 8'h1A, 15'h2FFF, {4'd10, 13'h0FFF}, 13'h0400, {7'd1,   10'h000}},
    {16'h8000, 8'h40, 15'h0005, {4'd14, 13'h0005}, 13'h0800, {7'd2,   10'h000}},
    {16'hC000, 8'h55, 15'h4007, {4'd3,  13'h0007}, 13'h0C3F, {7'd3,   10'h03F}},
    {16'h8001, 8'h2B, 15'h7FFF, {4'd15, 13'h1FFF}, 13'h0010, {7'd42,  10'h010}},
    {16'h8000, 8'h81, 15'h5000, {4'd14, 13'h1000}, 13'h1000, {7'd42,  10'h000}},
    {16'h8001, 8'hFF, 15'h3000, {4'd10, 13'h1000}, 13'h1FFF, {7'd127, 10'h3FF}},
    {16'h0001, 8'h05, 15'h0000, {4'd3,  13'h0000}, 13'h1800, {7'd126, 10'h000}},
    {16'h8000, 8'h85, 15'h0000, {4'd3,  13'h0000}, 13'h0000, {7'd4,   10'h000}},
    {16'h9FFF, 8'h93, 15'h6000, {4'd15, 13'h0000}, 13'h0C00, {7'd19,  10'h000}},
    {16'hA001, 8'hFF, 15'h2000, {4'd10, 13'h0000}, 13'h0C00, {7'd19,  10'h000}}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset layout, slots read back as expected identity patterns
    for (int s = 0; s < 4; s++) begin
      cpu_addr = {2'(s), 13'h0ABC};
      #1;
      check("R9 prg reset", 32'(prg_addr),
            32'({(s < 2) ? 4'(s) : 4'(12 + s), 13'h0ABC}));
    end
    for (int s = 0; s < 8; s++) begin
      ppu_addr = {3'(s), 10'h0AA};
      #1;
      check("R9 chr reset", 32'(chr_addr), 32'({7'(s), 10'h0AA}));
    end
    check("R9 mirror reset", 32'(mirror_mode), 32'(2'b00));

    // R3 R4 R5 R6 R10 R1: vector table
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][85:70], VEC[i][69:62]);
      cpu_addr = VEC[i][61:47];
      ppu_addr = VEC[i][29:17];
      #1;
      check($sformatf("R4 R6 R10 vec%0d prg", i), 32'(prg_addr), 32'(VEC[i][46:30]));
      check($sformatf("R3 R5 R6 vec%0d chr", i), 32'(chr_addr), 32'(VEC[i][16:0]));
    end

    // R2: interrupt strobes, combinational
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'hE001; wr_data = 8'h5A;
    #1;
    check("R2 strobe E001", 32'(irq_wr), 32'(4'b1000));
    check("R2 strobe data", 32'(irq_data), 32'(8'h5A));
    wr_addr = 16'hC000;
    #1;
    check("R2 strobe C000", 32'(irq_wr), 32'(4'b0001));
    wr_addr = 16'hFFFE;
    #1;
    check("R2 strobe E000 alias", 32'(irq_wr), 32'(4'b0100));
    wr_addr = 16'h6001;
    #1;
    check("R1 low half ignored", 32'(irq_wr), 32'(4'b0000));
    wr_en = 1'b0; wr_addr = 16'hC001;
    #1;
    check("R1 no enable", 32'(irq_wr), 32'(4'b0000));

    // R8: mirroring
    do_write(16'hA000, 8'h01);
    #1 check("R8 horizontal", 32'(mirror_mode), 32'(2'b01));
    do_write(16'hBFFE, 8'h00);
    #1 check("R8 vertical alias", 32'(mirror_mode), 32'(2'b00));
    do_write(16'hA001, 8'hFF);
    #1 check("R1 aux no effect", 32'(mirror_mode), 32'(2'b00));
    check("R8 four screen", 32'(mirror_mode_r), 32'(2'b10));

    // R7: RAM pattern configuration, after swap and bank writes
    do_write(16'h8000, 8'h80);
    do_write(16'h8001, 8'h33);
    for (int s = 0; s < 8; s++) begin
      ppu_addr = {3'(s), 10'h155};
      #1;
      check("R7 ram page", 32'(chr_addr_r), 32'({3'(s), 10'h155}));
    end

    // R9: reset again restores bank 6 in slot 0
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cpu_addr = 15'h0001;
    #1 check("R9 re-reset prg", 32'(prg_addr), 32'({4'd0, 13'h0001}));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule